// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers fifteen interrupt sources into one vectored request for a CPU. There are four external pins, each with its own selectable active edge, and eleven single-cycle pulse inputs from internal peripherals: the serial port, four timer matches, the converter done event, watchdog events and the interval-timer overflow. Each event sets a request flag. The flags sit in two byte-wide flag registers, and two byte-wide enable registers gate them. A master enable flag gates the whole set. A fixed-priority picker chooses the most urgent pending source.

When the master enable is set and any enabled flag is pending, the CPU sees a request. On the acknowledge cycle the block registers the identity and vector address of the winning source, and it clears the master enable so that nothing else is taken. It also clears the winner's flag when that source is edge-triggered. Strobes for disable, enable and return-from-service drive the master enable. A wake output releases stop or sleep whenever any enabled flag is pending, whatever the state of the master enable.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset, all of the following are 0: the flags, enables, edge selects, master enable, `irq_req`, `wake` and `vec_id`. `vec_addr` equals 0xFFFE.
- R2: Register map on the byte bus:
  - Source i lives in bit i of 0xEA (enable) and 0xEC (flag) for i < 8. For i >= 8 it lives in bit i-8 of 0xEB (enable) and 0xED (flag). Bit 7 of 0xEB and 0xED reads 0.
  - 0xEE holds the edge selects in bits 3:0, and its other bits read 0.
  - Any other address reads 0.
- R3: External pin k (sources 0 to 3) sets its flag on a rising edge when edge-select bit k is 1, and on a falling edge when it is 0. The flag reads back within four cycles of the pin change. An edge of the opposite polarity has no effect, and changing the edge select alone sets no flag.
- R4: A one-cycle pulse on `periph_pulse[k]` sets the flag of source 4+k.
- R5: A bus write to a flag register loads each bit: 0 clears the flag and 1 sets it. If a source event and a software clear of the same flag arrive in the same cycle, the event wins.
- R6: The disable strobe clears the master enable. The enable and return strobes set it, and the disable strobe wins when both arrive in the same cycle. `irq_req` is 1 exactly when the master enable is 1 and some flag is both set and enabled.
- R7: On a cycle with `cpu_ack` and `irq_req` both high, the block captures the lowest-numbered enabled pending source. From the next cycle `vec_id` shows that source and `vec_addr` shows 0xFFFE minus twice its number. An acknowledge while `irq_req` is low changes nothing.
- R8: An accepted acknowledge clears the master enable. It clears the winner's flag only for the external sources 0 to 3; flags of internal sources stay set until software clears them.
- R9: `wake` is 1 exactly when some flag is both set and enabled, whatever the state of the master enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 4 | Asynchronous external interrupt pins, sources 0 to 3 |
| periph_pulse | input | 11 | Peripheral event pulses, bit k is source 4+k |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational on address |
| di_stb | input | 1 | Clears master enable |
| ei_stb | input | 1 | Sets master enable |
| reti_stb | input | 1 | Return from service, sets master enable |
| cpu_ack | input | 1 | CPU accepts the pending request |
| irq_req | output | 1 | Request to the CPU |
| vec_addr | output | 16 | Vector address of the last accepted source |
| vec_id | output | 4 | Number of the last accepted source |
| wake | output | 1 | Releases stop or sleep |

## Verification
A flag stuck in a wrong state shows up in the readback of its flag register on the next bus read. It also shows in `wake` in the same cycle once the source is enabled. A master enable that is wrong shows up in `irq_req` one cycle after the strobe or acknowledge that should have moved it. A priority or vector error shows up in `vec_id` and `vec_addr` one cycle after the acknowledge. A missed hardware clear shows in the flag readback and in the next winner. Edge-detector faults take up to four cycles to appear, because of the synchronizer.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NUM_SRC = 15;
    localparam int NUM_EXT = 4;
    localparam int NUM_INT = NUM_SRC - NUM_EXT;
    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int BYTE_W  = 8;
    localparam int PAD_W   = 2 * BYTE_W;
    localparam int VEC_W   = 16;
    localparam int SYNC_STAGES = 2;

    localparam logic [BYTE_W-1:0] ADDR_EN_HI = 8'hEA;
    localparam logic [BYTE_W-1:0] ADDR_EN_LO = 8'hEB;
    localparam logic [BYTE_W-1:0] ADDR_FL_HI = 8'hEC;
    localparam logic [BYTE_W-1:0] ADDR_FL_LO = 8'hED;
    localparam logic [BYTE_W-1:0] ADDR_EDGE  = 8'hEE;

    localparam logic [VEC_W-1:0] VEC_BASE = 16'hFFFE;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [IDX_W-1:0]   src_idx_t;

    localparam src_vec_t HW_CLR_MASK = src_vec_t'((1 << NUM_EXT) - 1);

    typedef struct packed {
        logic     valid;
        src_idx_t idx;
    } pick_t;

    typedef struct packed {
        logic              we;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } bus_req_t;

    typedef enum logic [1:0] {
        IME_HOLD = 2'd0,
        IME_CLR  = 2'd1,
        IME_SET  = 2'd2
    } ime_op_e;

    function automatic logic [VEC_W-1:0] vec_of(input src_idx_t i);
        return VEC_BASE - {{(VEC_W-IDX_W-1){1'b0}}, i, 1'b0};
    endfunction

    function automatic logic [BYTE_W-1:0] flag_addr_of(input int i);
        return (i < BYTE_W) ? ADDR_FL_HI : ADDR_FL_LO;
    endfunction

    function automatic logic [BYTE_W-1:0] en_addr_of(input int i);
        return (i < BYTE_W) ? ADDR_EN_HI : ADDR_EN_LO;
    endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det
    import irq_pkg::*;
#(
    parameter int N = NUM_EXT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_async,
    input  logic [N-1:0] rise_sel,
    output logic [N-1:0] edge_hit
);

    for (genvar k = 0; k < N; k++) begin : g_pin
        logic [SYNC_STAGES-1:0] sync_q;
        logic                   prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q <= '0;
                prev_q <= 1'b0;
            end else begin
                sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async[k]};
                prev_q <= sync_q[SYNC_STAGES-1];
            end
        end

        // The edge depends only on the pin's history, so a change of
        // rise_sel alone cannot create a detection.
        always_comb begin
            if (rise_sel[k]) begin
                edge_hit[k] = sync_q[SYNC_STAGES-1] & ~prev_q;
            end else begin
                edge_hit[k] = ~sync_q[SYNC_STAGES-1] & prev_q;
            end
        end
    end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  bus_req_t            bus,
    input  src_vec_t            set_vec,
    input  src_vec_t            hw_clr,
    output src_vec_t            flags,
    output src_vec_t            enables,
    output logic [NUM_EXT-1:0]  edge_sel,
    output logic [BYTE_W-1:0]   rdata
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam logic [BYTE_W-1:0] FL_A = flag_addr_of(i);
        localparam logic [BYTE_W-1:0] EN_A = en_addr_of(i);
        localparam int                BITP = i % BYTE_W;

        logic fl_wr;
        logic en_wr;
        logic fl_next;

        assign fl_wr = bus.we && (bus.addr == FL_A);
        assign en_wr = bus.we && (bus.addr == EN_A);

        // Event set beats software write, which beats the acknowledge clear.
        always_comb begin
            fl_next = flags[i];
            if (hw_clr[i]) begin
                fl_next = 1'b0;
            end
            if (fl_wr) begin
                fl_next = bus.wdata[BITP];
            end
            if (set_vec[i]) begin
                fl_next = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i]   <= 1'b0;
                enables[i] <= 1'b0;
            end else begin
                flags[i] <= fl_next;
                if (en_wr) begin
                    enables[i] <= bus.wdata[BITP];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_sel <= '0;
        end else if (bus.we && (bus.addr == ADDR_EDGE)) begin
            edge_sel <= bus.wdata[NUM_EXT-1:0];
        end
    end

    logic [PAD_W-1:0] fl_pad;
    logic [PAD_W-1:0] en_pad;

    assign fl_pad = {{(PAD_W-NUM_SRC){1'b0}}, flags};
    assign en_pad = {{(PAD_W-NUM_SRC){1'b0}}, enables};

    always_comb begin
        unique case (bus.addr)
            ADDR_EN_HI: rdata = en_pad[BYTE_W-1:0];
            ADDR_EN_LO: rdata = en_pad[PAD_W-1:BYTE_W];
            ADDR_FL_HI: rdata = fl_pad[BYTE_W-1:0];
            ADDR_FL_LO: rdata = fl_pad[PAD_W-1:BYTE_W];
            ADDR_EDGE:  rdata = {{(BYTE_W-NUM_EXT){1'b0}}, edge_sel};
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_pkg::*;
(
    input  src_vec_t pend,
    output pick_t    win
);

    // Lower source number means higher priority.
    always_comb begin
        win = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                win.valid = 1'b1;
                win.idx   = src_idx_t'(i);
            end
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EXT-1:0] ext_pin,
    input  logic [NUM_INT-1:0] periph_pulse,
    input  logic               bus_we,
    input  logic [BYTE_W-1:0]  bus_addr,
    input  logic [BYTE_W-1:0]  bus_wdata,
    output logic [BYTE_W-1:0]  bus_rdata,
    input  logic               di_stb,
    input  logic               ei_stb,
    input  logic               reti_stb,
    input  logic               cpu_ack,
    output logic               irq_req,
    output logic [VEC_W-1:0]   vec_addr,
    output logic [IDX_W-1:0]   vec_id,
    output logic               wake
);

    bus_req_t            bus;
    logic [NUM_EXT-1:0]  edge_hit;
    logic [NUM_EXT-1:0]  edge_sel;
    src_vec_t            flags;
    src_vec_t            enables;
    src_vec_t            pend;
    src_vec_t            hw_clr;
    src_vec_t            win_onehot;
    pick_t               win;
    logic                ime_q;
    logic                take;
    ime_op_e             ime_op;

    assign bus = '{we: bus_we, addr: bus_addr, wdata: bus_wdata};

    irq_edge_det #(.N(NUM_EXT)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .pin_async (ext_pin),
        .rise_sel  (edge_sel),
        .edge_hit  (edge_hit)
    );

    irq_flag_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .bus      (bus),
        .set_vec  ({periph_pulse, edge_hit}),
        .hw_clr   (hw_clr),
        .flags    (flags),
        .enables  (enables),
        .edge_sel (edge_sel),
        .rdata    (bus_rdata)
    );

    assign pend = flags & enables;

    irq_prio_pick u_pick (
        .pend (pend),
        .win  (win)
    );

    assign wake    = |pend;
    assign irq_req = ime_q & win.valid;
    assign take    = cpu_ack & irq_req;

    always_comb begin
        win_onehot = '0;
        win_onehot[win.idx] = 1'b1;
    end

    assign hw_clr = take ? (win_onehot & HW_CLR_MASK) : '0;

    always_comb begin
        if (take || di_stb) begin
            ime_op = IME_CLR;
        end else if (ei_stb || reti_stb) begin
            ime_op = IME_SET;
        end else begin
            ime_op = IME_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ime_q    <= 1'b0;
            vec_id   <= '0;
            vec_addr <= VEC_BASE;
        end else begin
            unique case (ime_op)
                IME_CLR:  ime_q <= 1'b0;
                IME_SET:  ime_q <= 1'b1;
                default:  ime_q <= ime_q;
            endcase
            if (take) begin
                vec_id   <= win.idx;
                vec_addr <= vec_of(win.idx);
            end
        end
    end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              di_stb,
    input logic              cpu_ack,
    input logic              irq_req,
    input logic              wake,
    input logic [VEC_W-1:0]  vec_addr,
    input logic [IDX_W-1:0]  vec_id
);

    p_di_masks_r6: assert property (@(posedge clk) disable iff (rst)
        (di_stb && !cpu_ack) |=> !irq_req);

    p_ack_masks_r8: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && irq_req) |=> !irq_req);

    p_req_wakes_r9: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> wake);

    p_vec_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(cpu_ack && irq_req) |=> ($stable(vec_addr) && $stable(vec_id)));

    p_vec_map_r7: assert property (@(posedge clk) disable iff (rst)
        vec_addr == (VEC_BASE - {{(VEC_W-IDX_W-1){1'b0}}, vec_id, 1'b0}));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .di_stb   (di_stb),
    .cpu_ack  (cpu_ack),
    .irq_req  (irq_req),
    .wake     (wake),
    .vec_addr (vec_addr),
    .vec_id   (vec_id)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
    import irq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 20000;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_EXT-1:0] ext_pin = '0;
    logic [NUM_INT-1:0] periph_pulse = '0;
    logic               bus_we = 1'b0;
    logic [7:0]         bus_addr = '0;
    logic [7:0]         bus_wdata = '0;
    logic [7:0]         bus_rdata;
    logic               di_stb = 1'b0;
    logic               ei_stb = 1'b0;
    logic               reti_stb = 1'b0;
    logic               cpu_ack = 1'b0;
    logic               irq_req;
    logic [15:0]        vec_addr;
    logic [3:0]         vec_id;
    logic               wake;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .periph_pulse(periph_pulse),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .di_stb(di_stb), .ei_stb(ei_stb),
        .reti_stb(reti_stb), .cpu_ack(cpu_ack), .irq_req(irq_req),
        .vec_addr(vec_addr), .vec_id(vec_id), .wake(wake)
    );

    typedef struct packed {
        logic       we;
        logic [7:0] a;
        logic [7:0] d;
        logic [7:0] exp;
    } tvec_t;

    localparam int NT = 19;
    localparam tvec_t TBL [NT] = '{
        '{1'b1, 8'hEA, 8'hFF, 8'h00},
        '{1'b0, 8'hEA, 8'h00, 8'hFF},
        '{1'b1, 8'hEB, 8'hFF, 8'h00},
        '{1'b0, 8'hEB, 8'h00, 8'h7F},
        '{1'b1, 8'hEE, 8'hFF, 8'h00},
        '{1'b0, 8'hEE, 8'h00, 8'h0F},
        '{1'b0, 8'hF0, 8'h00, 8'h00},
        '{1'b1, 8'hEC, 8'hA5, 8'h00},
        '{1'b0, 8'hEC, 8'h00, 8'hA5},
        '{1'b1, 8'hED, 8'hFF, 8'h00},
        '{1'b0, 8'hED, 8'h00, 8'h7F},
        '{1'b1, 8'hEC, 8'h00, 8'h00},
        '{1'b0, 8'hEC, 8'h00, 8'h00},
        '{1'b1, 8'hED, 8'h00, 8'h00},
        '{1'b0, 8'hED, 8'h00, 8'h00},
        '{1'b1, 8'hEA, 8'h00, 8'h00},
        '{1'b1, 8'hEB, 8'h00, 8'h00},
        '{1'b1, 8'hEE, 8'h00, 8'h00},
        '{1'b0, 8'hEB, 8'h00, 8'h00}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1;
        chk(req, {8'h00, bus_rdata}, {8'h00, exp});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe_ei();
        @(negedge clk); ei_stb = 1'b1;
        @(negedge clk); ei_stb = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); cpu_ack = 1'b1;
        @(negedge clk); cpu_ack = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 irq_req", {15'd0, irq_req}, 16'd0);
        chk("R1 wake", {15'd0, wake}, 16'd0);
        chk("R1 vec_addr", vec_addr, 16'hFFFE);
        chk("R1 vec_id", {12'd0, vec_id}, 16'd0);
        rd("R1 flags hi", 8'hEC, 8'h00);
        rd("R1 edge sel", 8'hEE, 8'h00);

        // R2 / R5 register map walk
        for (int i = 0; i < NT; i++) begin
            if (TBL[i].we) wr(TBL[i].a, TBL[i].d);
            else rd("R2 R5 table", TBL[i].a, TBL[i].exp);
        end

        // R3 edge detection
        wr(8'hEE, 8'h01);
        @(negedge clk); ext_pin[0] = 1'b1;
        idle(4);
        rd("R3 rising pin0", 8'hEC, 8'h01);
        @(negedge clk); ext_pin[1] = 1'b1;
        idle(4);
        rd("R3 wrong polarity ignored", 8'hEC, 8'h01);
        @(negedge clk); ext_pin[1] = 1'b0;
        idle(4);
        rd("R3 falling pin1", 8'hEC, 8'h03);
        wr(8'hEC, 8'h00);
        wr(8'hEE, 8'h0E);
        idle(4);
        rd("R3 select change no flag", 8'hEC, 8'h00);

        // R4 peripheral pulses
        @(negedge clk); periph_pulse[0] = 1'b1;
        @(negedge clk); periph_pulse[0] = 1'b0;
        rd("R4 serial to src4", 8'hEC, 8'h10);
        @(negedge clk); periph_pulse[10] = 1'b1;
        @(negedge clk); periph_pulse[10] = 1'b0;
        rd("R4 src14", 8'hED, 8'h40);

        // R5 set wins over same-cycle software clear
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'hED; bus_wdata = 8'h00; periph_pulse[9] = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; periph_pulse[9] = 1'b0;
        rd("R5 set beats clear", 8'hED, 8'h20);

        // R6 / R9 master enable and wake
        wr(8'hEB, 8'h20);
        #1;
        chk("R9 wake with ime off", {15'd0, wake}, 16'd1);
        chk("R6 no req with ime off", {15'd0, irq_req}, 16'd0);
        strobe_ei(); #1;
        chk("R6 EI sets req", {15'd0, irq_req}, 16'd1);
        @(negedge clk); di_stb = 1'b1;
        @(negedge clk); di_stb = 1'b0; #1;
        chk("R6 DI clears req", {15'd0, irq_req}, 16'd0);
        @(negedge clk); di_stb = 1'b1; ei_stb = 1'b1;
        @(negedge clk); di_stb = 1'b0; ei_stb = 1'b0; #1;
        chk("R6 DI wins over EI", {15'd0, irq_req}, 16'd0);
        @(negedge clk); reti_stb = 1'b1;
        @(negedge clk); reti_stb = 1'b0; #1;
        chk("R6 RETI sets req", {15'd0, irq_req}, 16'd1);

        // R7 / R8 priority, vector, hardware clear
        wr(8'hEC, 8'h18);
        wr(8'hEA, 8'hFF);
        wr(8'hEB, 8'hFF);
        ack();
        chk("R7 id src3", {12'd0, vec_id}, 16'd3);
        chk("R7 vec src3", vec_addr, 16'hFFF8);
        chk("R8 ack clears ime", {15'd0, irq_req}, 16'd0);
        rd("R8 external flag cleared", 8'hEC, 8'h10);
        strobe_ei();
        ack();
        chk("R7 id src4", {12'd0, vec_id}, 16'd4);
        chk("R7 vec src4", vec_addr, 16'hFFF6);
        rd("R8 internal flag kept", 8'hEC, 8'h10);
        wr(8'hEC, 8'h00);
        strobe_ei();
        ack();
        chk("R7 id src13", {12'd0, vec_id}, 16'd13);
        chk("R7 vec src13", vec_addr, 16'hFFE4);
        rd("R8 internal flag kept lo", 8'hED, 8'h20);
        ack();
        chk("R7 ack without req ignored", {12'd0, vec_id}, 16'd13);
        chk("R7 vec unchanged", vec_addr, 16'hFFE4);
        chk("R9 wake while masked", {15'd0, wake}, 16'd1);

        done = 1'b1;
        finish_run();
    end

endmodule